// File: doc/BRIEF.md
# ATA Device Task-File Controller

This block is the register file that a storage device presents to its host across an ATA/ATAPI-style interface. It holds the task-file bytes (error, sector count, three address bytes, feature, device) together with status, control and a single interrupt-pending flag. Host accesses arrive over a simple synchronous register bus: writes take effect at the clock edge, and reads return the addressed byte combinationally in the same cycle.

Writing the command register starts the device-reset, packet or set-features command. A packet command arms a data-transfer engine to collect a fixed-length command packet. When that engine reports the packet complete, the block strobes the packet decoder. The decoder and other device logic can raise an interrupt or force an error status through side inputs. One interrupt request output reaches the host, gated by the interrupt-disable bit of the control register.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, reads return error 0x01, count 0x01, address low 0x81, address mid 0x14, address high 0xEB, device 0x00 and status 0x00, and the interrupt output is low. Register offsets are: 0 error (read) / feature (write), 1 count, 2 address low, 3 address mid, 4 address high, 5 device, 6 status (read) / command (write), 7 alternate status (read) / control (write).
- R2: A read at offset 6 clears the pending interrupt only when the BUSY bit (bit 7, driven by `dev_busy_i`) is 0. A read at offset 7 never clears it.
- R3: While control bit 1 is set, the interrupt output is low but a pending interrupt is kept. Clearing the bit drives the output high again if the interrupt is still pending.
- R4: Raising an interrupt that is already pending has no further effect. One acknowledge clears it. An acknowledge with nothing pending does nothing.
- R5: Any command write clears the pending interrupt, unless the command itself raises one.
- R6: Opcode 0xA0 (packet) sets count to 0x01 and sets DRQ (status bit 3). In the next cycle it pulses `xfer_arm_o` for one cycle, with `xfer_len_o` equal to 12.
- R7: Opcode 0xEF (set features) always raises an interrupt. If feature is 0x03 (set transfer mode), count bits 7:3 are published as the mode family and bits 2:0 as the mode number, and `mode_valid_o` is set. Any other feature value leaves the published mode unchanged.
- R8: After any command write, status has READY (bit 6) and SERVICE (bit 4) set and ERROR (bit 0) clear.
- R9: A pulse on `err_set_i` forces status to 0x51 and loads `err_code_i` into the error register.
- R10: Opcode 0x08 (device reset) reloads the R1 task-file values, clears DRQ and the pending interrupt, and leaves status at 0x50.
- R11: An unrecognised opcode changes only status and the pending interrupt. Count, address, device and error registers keep their values.
- R12: A pulse on `xfer_done_i` clears DRQ, and in the next cycle pulses `pkt_go_o` for one cycle.
- R13: Host writes to offsets 1 to 5 are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| dev_busy_i | input | 1 | Device busy, seen as status bit 7 |
| err_set_i | input | 1 | Force error status |
| err_code_i | input | 8 | Error code for the error register |
| irq_raise_i | input | 1 | Raise an interrupt (from packet decoder) |
| xfer_done_i | input | 1 | Transfer engine has received the packet |
| xfer_arm_o | output | 1 | Arm transfer engine for a command packet |
| xfer_len_o | output | 4 | Packet length in bytes |
| pkt_go_o | output | 1 | Hand-off strobe to the packet decoder |
| mode_valid_o | output | 1 | A transfer mode has been selected |
| mode_family_o | output | 5 | Selected transfer-mode family |
| mode_num_o | output | 3 | Selected transfer-mode number |
| irq_o | output | 1 | Interrupt request to host |

## Verification
The assertions check on every cycle that the pending flag rises only on a raise event and falls only on an acknowledge or command write. They also check that a busy status read leaves the flag set, that every command write leaves READY and SERVICE set with ERROR clear, that an error pulse forces 0x51, and that a packet command arms the engine one cycle later. The bench scenarios cover what needs an ordering of several accesses. These include masking and then unmasking a pending interrupt, the full signature after a device-reset command, and the register values kept across an unknown opcode. They also cover selecting a transfer mode and then leaving it unchanged with another feature code, and the packet hand-off sequence.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam int TF_DW = 8;

  localparam int ST_BSY = 7;
  localparam int ST_RDY = 6;
  localparam int ST_SRV = 4;
  localparam int ST_DRQ = 3;
  localparam int ST_ERR = 0;

  localparam logic [7:0] OP_DEV_RESET = 8'h08;
  localparam logic [7:0] OP_PACKET    = 8'hA0;
  localparam logic [7:0] OP_SET_FEAT  = 8'hEF;
  localparam logic [7:0] FEAT_XMODE   = 8'h03;

  localparam logic [7:0] SIG_ERR  = 8'h01;
  localparam logic [7:0] SIG_CNT  = 8'h01;
  localparam logic [7:0] SIG_LBA0 = 8'h81;
  localparam logic [7:0] SIG_LBA1 = 8'h14;
  localparam logic [7:0] SIG_LBA2 = 8'hEB;
  localparam logic [7:0] SIG_DEV  = 8'h00;
  localparam logic [7:0] ST_FORCED_ERR = 8'h51;

  typedef enum logic [2:0] {
    A_ERR_FEAT = 3'd0,
    A_COUNT    = 3'd1,
    A_LBA_LO   = 3'd2,
    A_LBA_MID  = 3'd3,
    A_LBA_HI   = 3'd4,
    A_DEVICE   = 3'd5,
    A_STAT_CMD = 3'd6,
    A_ALT_CTL  = 3'd7
  } tf_addr_e;

  typedef enum logic [2:0] {
    CK_NONE, CK_RESET, CK_PACKET, CK_SETF, CK_OTHER
  } cmd_kind_e;

  typedef struct packed {
    logic [TF_DW-1:0] err;
    logic [TF_DW-1:0] cnt;
    logic [TF_DW-1:0] lba0;
    logic [TF_DW-1:0] lba1;
    logic [TF_DW-1:0] lba2;
    logic [TF_DW-1:0] dev;
  } tf_file_t;

  function automatic tf_file_t f_signature();
    tf_file_t s;
    s.err  = SIG_ERR;
    s.cnt  = SIG_CNT;
    s.lba0 = SIG_LBA0;
    s.lba1 = SIG_LBA1;
    s.lba2 = SIG_LBA2;
    s.dev  = SIG_DEV;
    return s;
  endfunction

  function automatic logic [7:0] f_status_after_cmd(logic [7:0] st, logic set_drq);
    logic [7:0] r;
    r = st;
    r[ST_RDY] = 1'b1;
    r[ST_SRV] = 1'b1;
    r[ST_ERR] = 1'b0;
    if (set_drq) r[ST_DRQ] = 1'b1;
    return r;
  endfunction

  function automatic cmd_kind_e f_classify(logic [7:0] op);
    case (op)
      OP_DEV_RESET: return CK_RESET;
      OP_PACKET:    return CK_PACKET;
      OP_SET_FEAT:  return CK_SETF;
      default:      return CK_OTHER;
    endcase
  endfunction

  function automatic logic [4:0] f_mode_family(logic [7:0] cnt);
    return cnt[7:3];
  endfunction

  function automatic logic [2:0] f_mode_num(logic [7:0] cnt);
    return cnt[2:0];
  endfunction

endpackage

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_ev,
  input  logic clear_ev,
  input  logic irq_dis,
  output logic pending_o,
  output logic irq_o
);

  logic pending_q;

  // raise wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (raise_ev) pending_q <= 1'b1;
    else if (clear_ev) pending_q <= 1'b0;
  end

  assign pending_o = pending_q;
  assign irq_o     = pending_q & ~irq_dis;

  // R4: the flag only rises on a raise event
  p_rise_only_on_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !raise_ev) |=> !pending_q);

  // R3: the flag is kept while no clear event happens, whatever the mask
  p_kept_without_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !clear_ev) |=> pending_q);

endmodule

// File: rtl/ata_tf_cmd.sv
module ata_tf_cmd
  import ata_tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [TF_DW-1:0] cmd_op,
  input  logic [TF_DW-1:0] feature,
  input  logic [TF_DW-1:0] count,
  output cmd_kind_e        cmd_kind,
  output logic             setf_raise,
  output logic             mode_valid_o,
  output logic [4:0]       mode_family_o,
  output logic [2:0]       mode_num_o
);

  logic       xmode_sel;
  logic       mode_valid_q;
  logic [4:0] family_q;
  logic [2:0] num_q;

  always_comb begin
    cmd_kind = cmd_wr ? f_classify(cmd_op) : CK_NONE;
  end

  assign setf_raise = (cmd_kind == CK_SETF);
  assign xmode_sel  = setf_raise && (feature == FEAT_XMODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_valid_q <= 1'b0;
      family_q     <= '0;
      num_q        <= '0;
    end else if (xmode_sel) begin
      mode_valid_q <= 1'b1;
      family_q     <= f_mode_family(count);
      num_q        <= f_mode_num(count);
    end
  end

  assign mode_valid_o  = mode_valid_q;
  assign mode_family_o = family_q;
  assign mode_num_o    = num_q;

  // R7: a set-transfer-mode command publishes the count fields
  p_mode_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xmode_sel |=> (mode_valid_o && mode_family_o == $past(count[7:3])
                   && mode_num_o == $past(count[2:0])));

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tf_addr_e         addr,
  input  logic [TF_DW-1:0] wdata,
  input  logic             cmd_wr,
  input  cmd_kind_e        cmd_kind,
  input  logic             err_set,
  input  logic [TF_DW-1:0] err_code,
  input  logic             xfer_done,
  output tf_file_t         tf_o,
  output logic [TF_DW-1:0] status_o,
  output logic [TF_DW-1:0] feature_o,
  output logic             irq_dis_o
);

  tf_file_t         tf_q;
  logic [TF_DW-1:0] status_q;
  logic [TF_DW-1:0] feature_q;
  logic [TF_DW-1:0] control_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tf_q      <= f_signature();
      status_q  <= '0;
      feature_q <= '0;
      control_q <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_ERR_FEAT: feature_q <= wdata;
          A_COUNT:    tf_q.cnt  <= wdata;
          A_LBA_LO:   tf_q.lba0 <= wdata;
          A_LBA_MID:  tf_q.lba1 <= wdata;
          A_LBA_HI:   tf_q.lba2 <= wdata;
          A_DEVICE:   tf_q.dev  <= wdata;
          A_ALT_CTL:  control_q <= wdata;
          default: ;
        endcase
      end
      if (err_set) begin
        status_q <= ST_FORCED_ERR;
        tf_q.err <= err_code;
      end
      if (xfer_done) status_q[ST_DRQ] <= 1'b0;
      if (cmd_wr) begin
        case (cmd_kind)
          CK_RESET: begin
            tf_q     <= f_signature();
            status_q <= f_status_after_cmd(8'h00, 1'b0);
          end
          CK_PACKET: begin
            tf_q.cnt <= 8'h01;
            status_q <= f_status_after_cmd(status_q, 1'b1);
          end
          default: status_q <= f_status_after_cmd(status_q, 1'b0);
        endcase
      end
    end
  end

  assign tf_o      = tf_q;
  assign status_o  = status_q;
  assign feature_o = feature_q;
  assign irq_dis_o = control_q[1];

  // R8: a command write always ends with READY and SERVICE set, ERROR clear
  p_cmd_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (status_q[ST_RDY] && status_q[ST_SRV] && !status_q[ST_ERR]));

  // R9: an error pulse alone forces the fixed error status
  p_err_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set && !cmd_wr) |=> (status_q == ST_FORCED_ERR && tf_q.err == $past(err_code)));

  // R10: device reset restores the address signature
  p_reset_sig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_kind == CK_RESET) |=> (tf_q.lba0 == SIG_LBA0 && tf_q.lba1 == SIG_LBA1
                                           && tf_q.lba2 == SIG_LBA2 && !status_q[ST_DRQ]));

endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import ata_tf_pkg::*;
#(
  parameter int PKT_BYTES = 12,
  localparam int LEN_W = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [TF_DW-1:0] bus_wdata_i,
  output logic [TF_DW-1:0] bus_rdata_o,
  input  logic             dev_busy_i,
  input  logic             err_set_i,
  input  logic [TF_DW-1:0] err_code_i,
  input  logic             irq_raise_i,
  input  logic             xfer_done_i,
  output logic             xfer_arm_o,
  output logic [LEN_W-1:0] xfer_len_o,
  output logic             pkt_go_o,
  output logic             mode_valid_o,
  output logic [4:0]       mode_family_o,
  output logic [2:0]       mode_num_o,
  output logic             irq_o
);

  localparam logic [LEN_W-1:0] PKT_LEN = LEN_W'(PKT_BYTES);

  tf_addr_e         addr;
  logic             cmd_wr_ev;
  logic             stat_rd_ev;
  logic             stat_ack_ev;
  logic             irq_raise_ev;
  logic             irq_clear_ev;
  logic             setf_raise;
  logic             irq_pending;
  logic             irq_dis;
  cmd_kind_e        cmd_kind;
  tf_file_t         tf;
  logic [TF_DW-1:0] status;
  logic [TF_DW-1:0] status_rd;
  logic [TF_DW-1:0] feature;
  logic             arm_q;
  logic             go_q;

  assign addr         = tf_addr_e'(bus_addr_i);
  assign cmd_wr_ev    = bus_wr_i && (addr == A_STAT_CMD);
  assign stat_rd_ev   = bus_rd_i && (addr == A_STAT_CMD);
  assign status_rd    = {status[ST_BSY] | dev_busy_i, status[ST_BSY-1:0]};
  assign stat_ack_ev  = stat_rd_ev && !status_rd[ST_BSY];
  assign irq_raise_ev = irq_raise_i || setf_raise;
  assign irq_clear_ev = stat_ack_ev || cmd_wr_ev;

  ata_tf_cmd i_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr_ev),
    .cmd_op       (bus_wdata_i),
    .feature      (feature),
    .count        (tf.cnt),
    .cmd_kind     (cmd_kind),
    .setf_raise   (setf_raise),
    .mode_valid_o (mode_valid_o),
    .mode_family_o(mode_family_o),
    .mode_num_o   (mode_num_o)
  );

  ata_tf_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr_i),
    .addr     (addr),
    .wdata    (bus_wdata_i),
    .cmd_wr   (cmd_wr_ev),
    .cmd_kind (cmd_kind),
    .err_set  (err_set_i),
    .err_code (err_code_i),
    .xfer_done(xfer_done_i),
    .tf_o     (tf),
    .status_o (status),
    .feature_o(feature),
    .irq_dis_o(irq_dis)
  );

  ata_tf_irq i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise_ev (irq_raise_ev),
    .clear_ev (irq_clear_ev),
    .irq_dis  (irq_dis),
    .pending_o(irq_pending),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (addr)
      A_ERR_FEAT: bus_rdata_o = tf.err;
      A_COUNT:    bus_rdata_o = tf.cnt;
      A_LBA_LO:   bus_rdata_o = tf.lba0;
      A_LBA_MID:  bus_rdata_o = tf.lba1;
      A_LBA_HI:   bus_rdata_o = tf.lba2;
      A_DEVICE:   bus_rdata_o = tf.dev;
      default:    bus_rdata_o = status_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      arm_q <= (cmd_kind == CK_PACKET);
      go_q  <= xfer_done_i;
    end
  end

  assign xfer_arm_o = arm_q;
  assign xfer_len_o = PKT_LEN;
  assign pkt_go_o   = go_q;

  // R2: a status read while busy leaves the interrupt pending
  p_busy_no_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && stat_rd_ev && dev_busy_i && !cmd_wr_ev) |=> irq_pending);

  // R2: a status read while not busy acknowledges
  p_idle_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_ev && !dev_busy_i && !status[ST_BSY] && !irq_raise_i) |=> !irq_pending);

  // R5: a command write that raises nothing leaves no interrupt pending
  p_cmd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_ev && bus_wdata_i != OP_SET_FEAT && !irq_raise_i) |=> !irq_pending);

  // R6: packet command arms the engine next cycle with count 1 and DRQ
  p_packet_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_ev && bus_wdata_i == OP_PACKET) |=> (xfer_arm_o && tf.cnt == 8'h01 && status[ST_DRQ]));

  // R12: transfer done clears DRQ and hands off to the packet decoder
  p_done_handoff_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done_i && !cmd_wr_ev) |=> (pkt_go_o && !status[ST_DRQ]));

endmodule

// File: tb/test_ata_taskfile_ctrl.sv
module test_ata_taskfile_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       dev_busy_i = 1'b0, err_set_i = 1'b0;
  logic [7:0] err_code_i = '0;
  logic       irq_raise_i = 1'b0, xfer_done_i = 1'b0;
  logic       xfer_arm_o, pkt_go_o, mode_valid_o, irq_o;
  logic [3:0] xfer_len_o;
  logic [4:0] mode_family_o;
  logic [2:0] mode_num_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_taskfile_ctrl i_ata_taskfile_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .dev_busy_i(dev_busy_i), .err_set_i(err_set_i), .err_code_i(err_code_i),
    .irq_raise_i(irq_raise_i), .xfer_done_i(xfer_done_i), .xfer_arm_o(xfer_arm_o),
    .xfer_len_o(xfer_len_o), .pkt_go_o(pkt_go_o), .mode_valid_o(mode_valid_o),
    .mode_family_o(mode_family_o), .mode_num_o(mode_num_o), .irq_o(irq_o)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_rd_i = 1'b1; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_rd_i = 1'b0;
  endtask

  task automatic chk_reg(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic raise_irq();
    irq_raise_i = 1'b1;
    @(negedge clk);
    irq_raise_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", irq_o, 0);
    chk_reg("R1 error", 3'd0, 8'h01);
    chk_reg("R1 count", 3'd1, 8'h01);
    chk_reg("R1 lba lo", 3'd2, 8'h81);
    chk_reg("R1 lba mid", 3'd3, 8'h14);
    chk_reg("R1 lba hi", 3'd4, 8'hEB);
    chk_reg("R1 device", 3'd5, 8'h00);
    chk_reg("R1 status", 3'd7, 8'h00);
  endtask

  task automatic t_regs();
    wr(3'd1, 8'h5A); wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'hA0);
    chk_reg("R13 count", 3'd1, 8'h5A);
    chk_reg("R13 lba lo", 3'd2, 8'h11);
    chk_reg("R13 lba mid", 3'd3, 8'h22);
    chk_reg("R13 lba hi", 3'd4, 8'h33);
    chk_reg("R13 device", 3'd5, 8'hA0);
  endtask

  task automatic t_error();
    err_set_i = 1'b1; err_code_i = 8'h40;
    @(negedge clk);
    err_set_i = 1'b0;
    chk_reg("R9 status", 3'd7, 8'h51);
    chk_reg("R9 error", 3'd0, 8'h40);
  endtask

  task automatic t_unknown();
    raise_irq();
    check("R4 raise", irq_o, 1);
    wr(3'd6, 8'h55);
    check("R5 unknown clears irq", irq_o, 0);
    chk_reg("R11 status", 3'd7, 8'h50);
    chk_reg("R11 error kept", 3'd0, 8'h40);
    chk_reg("R11 count kept", 3'd1, 8'h5A);
    chk_reg("R11 lba hi kept", 3'd4, 8'h33);
    chk_reg("R11 device kept", 3'd5, 8'hA0);
  endtask

  task automatic t_packet();
    raise_irq();
    wr(3'd6, 8'hA0);
    check("R6 arm", xfer_arm_o, 1);
    check("R6 len", xfer_len_o, 12);
    check("R5 packet clears irq", irq_o, 0);
    @(negedge clk);
    check("R6 arm one cycle", xfer_arm_o, 0);
    chk_reg("R6 count", 3'd1, 8'h01);
    chk_reg("R6 R8 status", 3'd7, 8'h58);
  endtask

  task automatic t_done();
    xfer_done_i = 1'b1;
    @(negedge clk);
    xfer_done_i = 1'b0;
    check("R12 go", pkt_go_o, 1);
    chk_reg("R12 drq clear", 3'd7, 8'h50);
    check("R12 go one cycle", pkt_go_o, 0);
  endtask

  task automatic t_setfeat();
    wr(3'd0, 8'h03); wr(3'd1, 8'h0A);
    wr(3'd6, 8'hEF);
    check("R7 irq", irq_o, 1);
    check("R7 valid", mode_valid_o, 1);
    check("R7 family", mode_family_o, 1);
    check("R7 num", mode_num_o, 2);
    chk_reg("R8 status", 3'd7, 8'h50);
    wr(3'd0, 8'h02); wr(3'd1, 8'h44);
    wr(3'd6, 8'hEF);
    check("R7 other feature irq", irq_o, 1);
    check("R7 other feature family kept", mode_family_o, 1);
    check("R7 other feature num kept", mode_num_o, 2);
  endtask

  task automatic t_mask();
    wr(3'd7, 8'h02);
    check("R3 masked", irq_o, 0);
    chk_reg("R3 alt read", 3'd7, 8'h50);
    wr(3'd7, 8'h00);
    check("R3 unmasked pending", irq_o, 1);
  endtask

  task automatic t_busy();
    dev_busy_i = 1'b1;
    chk_reg("R2 busy status", 3'd6, 8'hD0);
    check("R2 busy no ack", irq_o, 1);
    dev_busy_i = 1'b0;
    chk_reg("R2 idle status", 3'd6, 8'h50);
    check("R2 idle ack", irq_o, 0);
  endtask

  task automatic t_double();
    raise_irq(); raise_irq();
    check("R4 double raise", irq_o, 1);
    chk_reg("R4 ack status", 3'd6, 8'h50);
    check("R4 single ack clears", irq_o, 0);
    chk_reg("R4 idle ack status", 3'd6, 8'h50);
    check("R4 ack nothing pending", irq_o, 0);
    raise_irq();
    check("R4 raise again", irq_o, 1);
  endtask

  task automatic t_devreset();
    wr(3'd1, 8'h77); wr(3'd2, 8'h01); wr(3'd3, 8'h02); wr(3'd4, 8'h03); wr(3'd5, 8'hB0);
    wr(3'd6, 8'hA0);
    wr(3'd6, 8'h08);
    check("R10 irq clear", irq_o, 0);
    chk_reg("R10 error", 3'd0, 8'h01);
    chk_reg("R10 count", 3'd1, 8'h01);
    chk_reg("R10 lba lo", 3'd2, 8'h81);
    chk_reg("R10 lba mid", 3'd3, 8'h14);
    chk_reg("R10 lba hi", 3'd4, 8'hEB);
    chk_reg("R10 device", 3'd5, 8'h00);
    chk_reg("R10 status", 3'd7, 8'h50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_error();
    t_unknown();
    t_packet();
    t_done();
    t_setfeat();
    t_mask();
    t_busy();
    t_double();
    t_devreset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule